// File: doc/BRIEF.md
# Asynchronous Processor Bus Slave with Synchronised Write Capture

This block sits on the memory bus of a processor whose bus is not timed to the FPGA clock. The bus has an active-low select, a direction line (low for write, high for read), an address and a shared bidirectional data bus. The block captures writes into a small register file, and it answers reads by driving the word at the addressed entry onto the shared data bus.

Every bus input goes through a two-flop synchroniser into the system clock domain. The falling edge of the synchronised select, seen while the direction line says write, becomes one system-clock enable. That enable latches the synchronised address and data into the register file and into a pair of capture outputs, and it raises a one-cycle valid flag. The read side has no clock. Its output enable is a combinational function of the raw select and direction lines, so the driver lets go of the bus in the same instant that select goes high.

Top module: `bsc_bus_slave`

## Requirements
- R1: While reset is held and in the cycle after it, `wr_valid` is 0, and `wr_addr` and `wr_data` are 0. Every register file entry reads back as 0 after reset.
- R2: When `bus_cs_n` falls while `bus_wr_n` is 0, `wr_valid` goes high for exactly one cycle. That cycle follows the third rising clock edge after the fall. It is 0 after the second edge and 0 again after the fourth.
- R3: In the cycle where `wr_valid` is 1, `wr_addr` and `wr_data` equal the address and data that were on the bus during the write. Both values hold until the next write.
- R4: Holding `bus_cs_n` low for many cycles produces only one `wr_valid` pulse. A new pulse needs `bus_cs_n` to go high and then low again.
- R5: A falling `bus_cs_n` while `bus_wr_n` is 1 (a read) produces no `wr_valid` pulse and changes no register entry.
- R6: If `bus_cs_n` is already low when reset is released, no `wr_valid` pulse follows. The first write after reset is taken only after `bus_cs_n` has been high and then falls.
- R7: `drive_en` is 1 exactly when `bus_cs_n` is 0 and `bus_wr_n` is 1. It is combinational, so it drops in the same time step that `bus_cs_n` rises. While `drive_en` is 1, `bus_data` carries the addressed register entry.
- R8: A read of an address returns the data of the last write captured to that address.
- R9: Successive writes to different addresses are each stored in their own entry, and none overwrites another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_wr_n | input | 1 | Bus direction: 0 for write, 1 for read |
| bus_addr | input | ADDR_W | Bus address selecting a register entry |
| bus_data | inout | DATA_W | Shared bidirectional data bus |
| wr_valid | output | 1 | One-cycle flag marking a captured write |
| wr_addr | output | ADDR_W | Address of the last captured write |
| wr_data | output | DATA_W | Data of the last captured write |
| drive_en | output | 1 | High while this block drives `bus_data` |

## Verification
The case that is hardest to reach from the ports is a select line that is already low when reset ends. Normal bus traffic never gives a falling edge without a preceding high phase, so this case does not arise on its own. To create it, the bench lowers select together with the write direction while reset is still held. It then counts `wr_valid` pulses for several cycles after release. Finally it raises and lowers select once and checks that exactly one capture follows. A second scenario holds select low for twenty cycles to show that a long strobe yields a single capture.

// File: rtl/bsc_pkg.sv
// Package: shared defaults for the asynchronous bus slave.
// Assumes: every user of these constants takes them as parameter defaults.
package bsc_pkg;
    localparam int BSC_DATA_W      = 8;
    localparam int BSC_ADDR_W      = 3;
    localparam int BSC_SYNC_STAGES = 2;
endpackage

// File: rtl/bsc_sync.sv
// Module: multi-bit flop chain that moves asynchronous bus inputs into the
// system clock domain.
// Assumes: the bus holds each grouped field stable across its strobe, so
// bits that resolve on different edges do not matter once the strobe is seen.
module bsc_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = bsc_pkg::BSC_SYNC_STAGES,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture of the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Purpose: each later stage lets metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bsc_wr_detect.sv
// Module: turns the synchronised select falling edge, qualified by the
// write direction, into a single-cycle capture enable.
// Assumes: select and direction arrive through the same synchroniser depth.
// The history flop resets low, so a select that is already low produces no
// edge.
module bsc_wr_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s_i,
    input  logic wr_n_s_i,
    output logic start_o
);
    logic cs_hist_q;

    // Purpose: remember the previous synchronised select level.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_hist_q <= 1'b0;
        else        cs_hist_q <= cs_n_s_i;
    end

    assign start_o = cs_hist_q & ~cs_n_s_i & ~wr_n_s_i;

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/bsc_regfile.sv
// Module: register file written by the capture enable, with capture outputs
// and an asynchronous read port.
// Assumes: address and data inputs are already synchronised and stable
// while start_i is high.
module bsc_regfile #(
    parameter int DATA_W = bsc_pkg::BSC_DATA_W,
    parameter int ADDR_W = bsc_pkg::BSC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Purpose: store the captured word in the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (start_i) begin
            mem_q[addr_i] <= data_i;
        end
    end

    // Purpose: hold the last captured address and data and flag the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                wr_addr_o <= addr_i;
                wr_data_o <= data_i;
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R3
    capture_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (wr_addr_o == $past(addr_i) && wr_data_o == $past(data_i)));

    // R8
    stored_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (mem_q[wr_addr_o] == wr_data_o));
endmodule

// File: rtl/bsc_bus_slave.sv
// Module: top of the asynchronous bus slave. Writes are captured through
// synchronisers and a single-cycle enable. Reads drive the shared bus under
// a combinational enable taken from the raw strobes.
// Assumes: the master holds address, data and direction stable while select
// is low, and keeps select low for at least three system clocks on a write.
module bsc_bus_slave #(
    parameter int DATA_W = bsc_pkg::BSC_DATA_W,
    parameter int ADDR_W = bsc_pkg::BSC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive_en
);
    localparam int CTRL_W = 2;

    logic [CTRL_W-1:0] ctrl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              start;
    logic [DATA_W-1:0] rd_word;

    bsc_sync #(.W(CTRL_W), .RST_VAL(2'b10)) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .d_i({bus_wr_n, bus_cs_n}), .q_o(ctrl_s));

    bsc_sync #(.W(ADDR_W)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d_i(bus_addr), .q_o(addr_s));

    bsc_sync #(.W(DATA_W)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d_i(bus_data), .q_o(data_s));

    bsc_wr_detect u_detect (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s_i(ctrl_s[0]), .wr_n_s_i(ctrl_s[1]), .start_o(start));

    bsc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .addr_i(addr_s), .data_i(data_s),
        .rd_addr_i(bus_addr), .rd_data_o(rd_word),
        .valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

    // Combinational read enable: the driver follows the raw strobes.
    assign drive_en = ~bus_cs_n & bus_wr_n;
    assign bus_data = drive_en ? rd_word : {DATA_W{1'bz}};

    // R7
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (bus_data == rd_word));

    // R5
    no_read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> !start);
endmodule

// File: tb/bsc_bus_slave_test.sv
module bsc_bus_slave_test;
    localparam int CLK_P  = 10;
    localparam int DW     = 8;
    localparam int AW     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs_n = 1'b1;
    logic          bus_wr_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          tb_oe = 1'b0;
    logic [DW-1:0] tb_dat = '0;
    wire  [DW-1:0] bus_data;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          drive_en;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    assign bus_data = tb_oe ? tb_dat : {DW{1'bz}};

    bsc_bus_slave #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .drive_en(drive_en));

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) if (rst_n && wr_valid) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; bus_cs_n = 1'b1; bus_wr_n = 1'b1; tb_oe = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(posedge clk); #(CLK_P/4);
        check(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
        check(wr_addr == 0 && wr_data == 0, "R1 capture regs", wr_data, 0);
    endtask

    // Full write cycle with pulse timing and capture checks (R2, R3).
    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr_n = 1'b0; bus_addr = a; tb_dat = d; tb_oe = 1'b1;
        @(negedge clk);
        bus_cs_n = 1'b0;
        repeat (2) @(posedge clk); #(CLK_P/4);
        check(wr_valid == 0, "R2 early", wr_valid, 0);
        @(posedge clk); #(CLK_P/4);
        check(wr_valid == 1, "R2 pulse", wr_valid, 1);
        check(wr_addr == a, "R3 addr", wr_addr, a);
        check(wr_data == d, "R3 data", wr_data, d);
        @(posedge clk); #(CLK_P/4);
        check(wr_valid == 0, "R2 end", wr_valid, 0);
        @(negedge clk);
        bus_cs_n = 1'b1; tb_oe = 1'b0; bus_wr_n = 1'b1;
        idle(4);
        check(wr_addr == a && wr_data == d, "R3 hold", wr_data, d);
    endtask

    // Read cycle: combinational enable and returned data (R7, R8, R5).
    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        int p0;
        @(negedge clk);
        p0 = pulses;
        bus_wr_n = 1'b1; bus_addr = a; tb_oe = 1'b0;
        #1 check(drive_en == 0, "R7 idle", drive_en, 0);
        bus_cs_n = 1'b0;
        #1 check(drive_en == 1, "R7 enable", drive_en, 1);
        check(bus_data == exp, req, bus_data, exp);
        idle(5);
        bus_cs_n = 1'b1;
        #1 check(drive_en == 0, "R7 release", drive_en, 0);
        idle(4);
        check(pulses == p0, "R5 no pulse on read", pulses - p0, 0);
    endtask

    // Long select low yields a single capture (R4).
    task automatic t_hold_low();
        int p0;
        @(negedge clk);
        p0 = pulses;
        bus_wr_n = 1'b0; bus_addr = 3'd6; tb_dat = 8'h3C; tb_oe = 1'b1;
        @(negedge clk); bus_cs_n = 1'b0;
        idle(20);
        check(pulses == p0 + 1, "R4 single pulse", pulses - p0, 1);
        bus_cs_n = 1'b1; idle(4);
        bus_cs_n = 1'b0; idle(6);
        check(pulses == p0 + 2, "R4 re-arm", pulses - p0, 2);
        bus_cs_n = 1'b1; tb_oe = 1'b0; bus_wr_n = 1'b1; idle(4);
    endtask

    // Select already low at reset release (R6).
    task automatic t_cs_low_reset();
        int p0;
        @(negedge clk);
        rst_n = 1'b0; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        bus_addr = 3'd1; tb_dat = 8'h77; tb_oe = 1'b1;
        idle(3);
        rst_n = 1'b1;
        p0 = pulses;
        idle(8);
        check(pulses == p0, "R6 no spurious", pulses - p0, 0);
        bus_cs_n = 1'b1; idle(4);
        bus_cs_n = 1'b0; idle(6);
        check(pulses == p0 + 1, "R6 first write", pulses - p0, 1);
        check(wr_data == 8'h77, "R6 data", wr_data, 8'h77);
        bus_cs_n = 1'b1; tb_oe = 1'b0; bus_wr_n = 1'b1; idle(4);
    endtask

    initial begin
        t_reset();
        t_read(3'd4, 8'h00, "R1 entry cleared");
        t_write(3'd2, 8'hA5);
        t_read(3'd2, 8'hA5, "R8 read back");
        t_write(3'd5, 8'h5A);
        t_write(3'd0, 8'hFF);
        t_read(3'd5, 8'h5A, "R9 entry 5");
        t_read(3'd2, 8'hA5, "R9 entry 2");
        t_read(3'd0, 8'hFF, "R9 entry 0");
        t_hold_low();
        t_read(3'd6, 8'h3C, "R8 after long write");
        t_cs_low_reset();
        t_read(3'd1, 8'h77, "R6 stored");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule